// File: doc/BRIEF.md
# Interleaved Fragment Router with Switch-Token Broadcast

This block sits behind one rasterizer or fragment stage. It takes a single ordered stream of items. Each item is either a fragment, which carries a screen position and a data word, or a "next" marker that ends a batch of work from this source. It spreads these items over `NUM_LANES` output lanes, one lane for each frame-buffer unit. Screen ownership is interleaved. The position is divided into tiles of `2**TILE_LOG2` pixels on a side, and the lane is the sum of the tile column and the tile row, taken modulo the lane count. With two lanes and single-pixel tiles this sum reduces to `x[0] XOR y[0]`, which gives a checkerboard: `0 1` on one row and `1 0` on the next.

A fragment goes to exactly one lane. A "next" marker is turned into a switch item and copied onto every lane, so each frame-buffer unit learns where this source's batch ends. Each lane has its own queue of `Q_DEPTH` entries. When the queue a fragment needs is full, the input stalls. A switch broadcast finishes only after every lane has taken its copy. Lanes that have room take their copy at once, and the input stays stalled until the last lane catches up.

Both the input and each output lane use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. While valid is high and ready is low, the source must hold valid and all item fields steady. `in_ready` is a function of the current item (its kind, and the owning lane for a fragment) and of the queue state only. It never depends on `in_valid`. An output lane presents the head of its queue and keeps it steady until it is taken.

Top module: `frag_router`

## Requirements
- R1: After reset, every `out_valid` is low, and `in_ready` is high for a fragment offered to any lane.
- R2: A fragment at (x, y) is written only to lane `((x >> TILE_LOG2) + (y >> TILE_LOG2)) mod NUM_LANES`. With 4 lanes and single-pixel tiles, (3,2) goes to lane 1 and (0,0), (1,3), (2,2), (3,1) all go to lane 0.
- R3: An item accepted on an edge is visible on an empty lane's output right after that edge, with one register of latency. A lane's `out_valid` is high exactly when its queue holds an item.
- R4: Each lane presents its items in the order they were accepted, and each fragment keeps its x, y and data fields.
- R5: Each accepted "next" marker (`in_tok`=1) puts exactly one switch item on every lane, in its place among the fragments. On the output, a switch item shows `out_tok`=1 and a fragment shows `out_tok`=0.
- R6: While a marker is offered, `in_ready` stays low until every lane that still lacks its switch copy has a free entry. A lane with room takes its copy at once, and a lane never takes a second copy of the same marker.
- R7: A fragment whose lane queue is full sees `in_ready` low. `in_ready` returns high on the cycle after an edge that pops that lane.
- R8: A lane with `out_valid` high and `out_ready` low keeps `out_valid` high and all of its fields unchanged on the next cycle.
- R9: The x, y and data inputs of a marker are ignored. A switch item carries x, y and data equal to zero.
- R10: Each lane queue accepts `Q_DEPTH` items (4 by default) without stalling the input before it reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item will be taken at the next edge |
| in_tok | input | 1 | 1 = "next" marker, 0 = fragment |
| in_x | input | X_W | Fragment screen column |
| in_y | input | Y_W | Fragment screen row |
| in_data | input | DATA_W | Fragment data word |
| out_valid | output | NUM_LANES | Per-lane item present |
| out_ready | input | NUM_LANES | Per-lane consumer takes the head item |
| out_tok | output | NUM_LANES | Per-lane: head item is a switch |
| out_x | output | NUM_LANES*X_W | Per-lane column, lane i at bits [i*X_W +: X_W] |
| out_y | output | NUM_LANES*Y_W | Per-lane row, lane i at bits [i*Y_W +: Y_W] |
| out_data | output | NUM_LANES*DATA_W | Per-lane data, lane i at bits [i*DATA_W +: DATA_W] |

## Verification
`in_ready` is combinational, so its expected value applies in the same cycle as the offered item. A pushed item appears on an empty lane one edge after it is accepted. A pop frees queue space for `in_ready` one edge after the pop. The bench drives inputs on the falling edge, waits a short delay, and only then compares `in_ready` and every lane's head item against a behavioural model. The model advances with exactly the transfers that the next rising edge will perform. Directed checks sample at these points to cover the mapping example, a full queue, the release of a stall, and a broadcast that is partly blocked.

// File: rtl/frag_router_pkg.sv
package frag_router_pkg;

  // Kind bit stored at the top of every queue entry.
  typedef enum logic {
    ITEM_FRAG   = 1'b0,
    ITEM_SWITCH = 1'b1
  } item_kind_e;

endpackage

// File: rtl/frag_router_map.sv
// Interleaved screen-ownership map: lane = (tile column + tile row) mod lanes.
module frag_router_map #(
  parameter int X_W       = 12,
  parameter int Y_W       = 12,
  parameter int NUM_LANES = 4,
  parameter int TILE_LOG2 = 0
) (
  input  logic [X_W-1:0]                 x,
  input  logic [Y_W-1:0]                 y,
  output logic [$clog2(NUM_LANES)-1:0]   lane_idx,
  output logic [NUM_LANES-1:0]           lane_sel
);
  localparam int LANE_W = $clog2(NUM_LANES);

  // Power-of-two lane count: modulo is a truncation of the tile-index sum.
  assign lane_idx = LANE_W'((x >> TILE_LOG2) + (y >> TILE_LOG2));

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_sel
    assign lane_sel[i] = (lane_idx == LANE_W'(i));
  end
endmodule

// File: rtl/frag_router_lane_q.sv
// One frame-buffer lane queue: registered storage, head presented directly.
module frag_router_lane_q #(
  parameter int W     = 41,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full       = (count == CNT_W'(DEPTH));
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R10: the router never pushes into a queue that reports full.
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R8: an untaken head item stays presented and unchanged.
  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !pop) |=> (head_valid && $stable(head_data)));
endmodule

// File: rtl/frag_router_bcast.sv
// Tracks which lanes already hold the switch copy of the pending marker.
module frag_router_bcast #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tok_req,
  input  logic [NUM_LANES-1:0] lane_full,
  output logic [NUM_LANES-1:0] tok_push,
  output logic [NUM_LANES-1:0] served,
  output logic                 tok_done
);
  assign tok_push = {NUM_LANES{tok_req}} & ~served & ~lane_full;
  assign tok_done = &(served | ~lane_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served <= '0;
    end else if (tok_req) begin
      if (tok_done) served <= '0;
      else          served <= served | tok_push;
    end
  end

  // R6: once a broadcast completes, the next marker starts with no lane served.
  assert_served_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_req && tok_done) |=> (served == '0));
endmodule

// File: rtl/frag_router.sv
module frag_router
  import frag_router_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int X_W       = 12,
  parameter int Y_W       = 12,
  parameter int DATA_W    = 16,
  parameter int TILE_LOG2 = 0,
  parameter int Q_DEPTH   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_tok,
  input  logic [X_W-1:0]              in_x,
  input  logic [Y_W-1:0]              in_y,
  input  logic [DATA_W-1:0]           in_data,
  output logic [NUM_LANES-1:0]        out_valid,
  input  logic [NUM_LANES-1:0]        out_ready,
  output logic [NUM_LANES-1:0]        out_tok,
  output logic [NUM_LANES*X_W-1:0]    out_x,
  output logic [NUM_LANES*Y_W-1:0]    out_y,
  output logic [NUM_LANES*DATA_W-1:0] out_data
);
  localparam int LANE_W  = $clog2(NUM_LANES);
  localparam int BODY_W  = X_W + Y_W + DATA_W;
  localparam int ENTRY_W = 1 + BODY_W;

  logic [LANE_W-1:0]    dest_idx;
  logic [NUM_LANES-1:0] dest_sel, lane_full, frag_push, tok_push, lane_push, served;
  logic                 tok_done;
  item_kind_e           kind;
  logic [ENTRY_W-1:0]   push_entry;
  logic [ENTRY_W-1:0]   head [NUM_LANES];

  frag_router_map #(
    .X_W(X_W), .Y_W(Y_W), .NUM_LANES(NUM_LANES), .TILE_LOG2(TILE_LOG2)
  ) u_map (
    .x(in_x), .y(in_y), .lane_idx(dest_idx), .lane_sel(dest_sel)
  );

  frag_router_bcast #(.NUM_LANES(NUM_LANES)) u_bcast (
    .clk(clk), .rst_n(rst_n), .tok_req(in_valid && in_tok),
    .lane_full(lane_full), .tok_push(tok_push), .served(served),
    .tok_done(tok_done)
  );

  assign kind       = in_tok ? ITEM_SWITCH : ITEM_FRAG;
  assign push_entry = in_tok ? {kind, BODY_W'(0)} : {kind, in_x, in_y, in_data};
  assign in_ready   = in_tok ? tok_done : !lane_full[dest_idx];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign frag_push[i] = in_valid && !in_tok && dest_sel[i] && !lane_full[i];
    assign lane_push[i] = frag_push[i] || tok_push[i];

    frag_router_lane_q #(.W(ENTRY_W), .DEPTH(Q_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(lane_push[i]), .push_data(push_entry),
      .pop(out_valid[i] && out_ready[i]),
      .full(lane_full[i]), .head_valid(out_valid[i]), .head_data(head[i])
    );

    assign out_tok[i]                     = head[i][ENTRY_W-1];
    assign out_x[i*X_W +: X_W]            = head[i][BODY_W-1 -: X_W];
    assign out_y[i*Y_W +: Y_W]            = head[i][DATA_W+Y_W-1 -: Y_W];
    assign out_data[i*DATA_W +: DATA_W]   = head[i][DATA_W-1:0];
  end

  // R2: an accepted fragment lands in exactly one lane.
  assert_frag_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_tok) |-> ($countones(lane_push) == 1));

  // R5: when a marker is accepted, every lane has its copy or is taking it now.
  assert_token_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tok) |-> (&(served | tok_push)));
endmodule

// File: tb/tb_frag_router.sv
module tb_frag_router;
  localparam int LANES = 4;
  localparam int XW = 12;
  localparam int YW = 12;
  localparam int DW = 16;
  localparam int TL = 0;
  localparam int QD = 4;
  localparam int EW = 1 + XW + YW + DW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_tok = 1'b0;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic [DW-1:0] in_data = '0;
  logic [LANES-1:0] out_valid, out_tok;
  logic [LANES-1:0] out_ready = '0;
  logic [LANES*XW-1:0] out_x;
  logic [LANES*YW-1:0] out_y;
  logic [LANES*DW-1:0] out_data;

  frag_router #(.NUM_LANES(LANES), .X_W(XW), .Y_W(YW), .DATA_W(DW),
                .TILE_LOG2(TL), .Q_DEPTH(QD)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tok(in_tok), .in_x(in_x), .in_y(in_y), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_tok(out_tok),
    .out_x(out_x), .out_y(out_y), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  logic [EW-1:0] mq [LANES][$];
  logic [LANES-1:0] mdone = '0;
  int ready_mode = 0;
  logic [LANES-1:0] ready_vec = '0;
  logic s_valid = 1'b0, s_tok = 1'b0;
  logic [XW-1:0] s_x = '0;
  logic [YW-1:0] s_y = '0;
  logic [DW-1:0] s_d = '0;
  logic last_rdy;

  function automatic int exp_lane(int x, int y);
    return ((x >> TL) + (y >> TL)) % LANES;
  endfunction

  function automatic logic [EW-1:0] lane_item(int i);
    return {out_tok[i], out_x[i*XW +: XW], out_y[i*YW +: YW], out_data[i*DW +: DW]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive staged inputs at the falling edge, compare, advance model.
  task automatic step();
    bit exp_rdy, comp;
    bit [LANES-1:0] full_pre, pushed;
    int l;
    @(negedge clk);
    in_valid = s_valid; in_tok = s_tok; in_x = s_x; in_y = s_y; in_data = s_d;
    for (int i = 0; i < LANES; i++) begin
      case (ready_mode)
        0: out_ready[i] = 1'b0;
        1: out_ready[i] = 1'b1;
        2: out_ready[i] = ($urandom_range(0, 2) != 0);
        default: out_ready[i] = ready_vec[i];
      endcase
    end
    #1;
    for (int i = 0; i < LANES; i++) full_pre[i] = (mq[i].size() == QD);
    comp = 1'b1;
    for (int i = 0; i < LANES; i++) if (!mdone[i] && full_pre[i]) comp = 1'b0;
    exp_rdy = in_tok ? comp : !full_pre[exp_lane(int'(in_x), int'(in_y))];
    last_rdy = in_ready;
    check(in_ready == exp_rdy, in_tok ? "R6" : "R7", "in_ready", 64'(in_ready), 64'(exp_rdy));
    for (int i = 0; i < LANES; i++) begin
      check(out_valid[i] == (mq[i].size() > 0), "R3", $sformatf("out_valid lane %0d", i),
            64'(out_valid[i]), 64'(mq[i].size() > 0));
      if (mq[i].size() > 0)
        check(lane_item(i) == mq[i][0], mq[i][0][EW-1] ? "R5 R9" : "R4",
              $sformatf("head lane %0d", i), 64'(lane_item(i)), 64'(mq[i][0]));
    end
    for (int i = 0; i < LANES; i++)
      if (out_ready[i] && mq[i].size() > 0) void'(mq[i].pop_front());
    if (in_valid) begin
      if (!in_tok) begin
        l = exp_lane(int'(in_x), int'(in_y));
        if (!full_pre[l]) mq[l].push_back({1'b0, in_x, in_y, in_data});
      end else begin
        pushed = '0;
        for (int i = 0; i < LANES; i++)
          if (!mdone[i] && !full_pre[i]) begin
            mq[i].push_back({1'b1, {(EW-1){1'b0}}});
            pushed[i] = 1'b1;
          end
        if (comp) mdone = '0;
        else mdone = mdone | pushed;
      end
    end
  endtask

  task automatic send(input bit tok, input int x, input int y, input int d, output int waits);
    s_valid = 1'b1; s_tok = tok; s_x = XW'(x); s_y = YW'(y); s_d = DW'(d);
    waits = 0;
    do begin
      step();
      waits++;
    end while (!last_rdy);
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0; s_tok = 1'b0;
    repeat (n) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [EW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == '0, "R1", "out_valid after reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);

    // R2 / R3: (3,2) lands in lane 1 one edge after acceptance
    ready_mode = 0;
    send(1'b0, 3, 2, 'h11, w);
    idle(1);
    check(out_valid == 4'b0010, "R2", "lane of (3,2)", 64'(out_valid), 64'h2);
    check(out_x[1*XW +: XW] == 3 && out_data[1*DW +: DW] == 'h11, "R3", "lane 1 head",
          64'(out_data[1*DW +: DW]), 64'h11);

    // R10: four fragments for lane 0 each go in without waiting
    send(1'b0, 0, 0, 'h20, w); check(w == 1, "R10", "entry 1 waits", 64'(w), 1);
    send(1'b0, 1, 3, 'h21, w); check(w == 1, "R10", "entry 2 waits", 64'(w), 1);
    send(1'b0, 2, 2, 'h22, w); check(w == 1, "R10", "entry 3 waits", 64'(w), 1);
    send(1'b0, 3, 1, 'h23, w); check(w == 1, "R10", "entry 4 waits", 64'(w), 1);

    // R7 / R8: fifth lane-0 fragment stalls, head holds, pop releases
    s_valid = 1'b1; s_tok = 1'b0; s_x = 4; s_y = 0; s_d = 'h24;
    step();
    check(last_rdy == 1'b0, "R7", "in_ready with lane 0 full", 64'(last_rdy), 0);
    held = lane_item(0);
    repeat (3) step();
    check(lane_item(0) == held && out_valid[0], "R8", "lane 0 head held", 64'(lane_item(0)), 64'(held));
    ready_mode = 3; ready_vec = 4'b0001;
    step();
    check(last_rdy == 1'b0, "R7", "in_ready on pop cycle", 64'(last_rdy), 0);
    ready_vec = 4'b0000;
    step();
    check(last_rdy == 1'b1, "R7", "in_ready after pop", 64'(last_rdy), 1);
    idle(1);

    // drain
    ready_mode = 1;
    idle(12);
    check(out_valid == '0, "R4", "drained", 64'(out_valid), 0);

    // R6 / R9: marker with lane 2 full
    ready_mode = 0;
    send(1'b0, 2, 0, 'h30, w);
    send(1'b0, 1, 1, 'h31, w);
    send(1'b0, 0, 2, 'h32, w);
    send(1'b0, 3, 3, 'h33, w);
    s_valid = 1'b1; s_tok = 1'b1; s_x = '1; s_y = '1; s_d = '1;
    step();
    check(last_rdy == 1'b0, "R6", "marker blocked by lane 2", 64'(last_rdy), 0);
    step(); step();
    check(out_tok == 4'b1011, "R6", "early copies on free lanes", 64'(out_tok), 64'hb);
    check(out_x[0 +: XW] == 0 && out_data[0 +: DW] == 0, "R9", "switch fields zero",
          64'(out_data[0 +: DW]), 0);
    ready_mode = 3; ready_vec = 4'b0100;
    step();
    ready_vec = 4'b0000;
    step();
    check(last_rdy == 1'b1, "R6", "marker completes after lane 2 pop", 64'(last_rdy), 1);
    idle(1);
    ready_mode = 1;
    idle(12);

    // R4 / R5: random mix under random back-pressure
    ready_mode = 2;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else send($urandom_range(0, 7) == 0, int'($urandom_range(0, 4095)),
                int'($urandom_range(0, 4095)), int'($urandom_range(0, 65535)), w);
    end
    ready_mode = 1;
    idle(20);
    check(out_valid == '0, "R5", "all lanes drained", 64'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule